// File: doc/BRIEF.md
# RTC Alarm Match with Repeat Masks

This unit is the alarm side of a real-time clock. It keeps four byte-wide alarm registers (seconds, minutes, hours, day of month), each holding a packed BCD value in its low bits and a mask flag in bit 7. On every one-second tick it compares the armed fields against the running time-of-day supplied by the calendar counter. When they agree it raises a sticky alarm flag and, if the alarm is enabled, emits a one-cycle interrupt pulse.

The pattern of mask flags selects how often the alarm repeats. With no mask set, the unit compares the date, hour, minute and second, which gives a monthly alarm. Masking only the date gives a daily alarm. Adding the hour mask gives an hourly alarm, and adding the minute mask as well gives an alarm every minute. Any other pattern fires on every tick. Software reaches the registers through a simple byte port with a combinational read path. Writes that carry out-of-range BCD are dropped, so the stored alarm time is always legal.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset (rst_ni low), all four alarm registers, the enable bit and the alarm flag read 0x00, and irq_o is low.
- R2: Address 0 holds alarm seconds, 1 minutes, 2 hours and 3 date. Address 4 is the control register, with the alarm enable in bit 0. Address 5 is the status register, with the alarm flag in bit 0. Other addresses read 0x00. An accepted alarm write stores all 8 bits and reads back unchanged.
- R3: The decoded value of a BCD byte field v is 10*(upper digit)+(lower nibble), with no digit check. A write to alarm seconds or minutes is accepted only if the decoded value of wdata[6:0] is at most 59. Otherwise the register keeps its old value.
- R4: A write to alarm hours is accepted only if the decoded value of wdata[5:0] is at most 23.
- R5: A write to alarm date is accepted only if the decoded value of wdata[5:0] is nonzero.
- R6: With all four mask bits (bit 7) clear, a tick matches only when date[5:0], hours[5:0], minutes[6:0] and seconds[6:0] all equal the corresponding time inputs.
- R7: With only the date mask set, a tick matches when hours, minutes and seconds are equal, whatever the date.
- R8: With the date and hours masks set and the minutes and seconds masks clear, a tick matches when minutes and seconds are equal.
- R9: With the date, hours and minutes masks set and the seconds mask clear, a tick matches when seconds are equal.
- R10: Every other mask pattern matches on every tick.
- R11: A match is evaluated only in a cycle with tick_i high. irq_o goes high for exactly the cycle after a matching tick, and only if the enable bit was set in the tick cycle.
- R12: The alarm flag is set after every matching tick, whatever the enable. A read strobe (rd_en_i) at address 5 clears the flag after that cycle. If a matching tick arrives in the same cycle, the set takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effect: clears the flag on a status read) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| tick_i | input | 1 | One-second tick, one cycle wide |
| sec_i | input | 8 | Current seconds, BCD |
| min_i | input | 8 | Current minutes, BCD |
| hour_i | input | 8 | Current hours, BCD |
| date_i | input | 8 | Current day of month, BCD |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
A wrong alarm register shows on the combinational read port in the same cycle it is read, and at the next matching tick as a missing or extra irq_o pulse. A wrong decode of the mask pattern shows only at the next tick whose time differs from the alarm in exactly the field that decides the mode. The bench therefore pairs every mode with a hit tick and a near-miss tick. A flag that is stuck or cleared too early shows on the status read in the cycle after the event that should have changed it, and irq_o is compared on every clock.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int unsigned NUM_FIELDS = 4;
  localparam int unsigned FLD_SEC  = 0;
  localparam int unsigned FLD_MIN  = 1;
  localparam int unsigned FLD_HOUR = 2;
  localparam int unsigned FLD_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_e;

  // tens digit * 10 + low nibble, no digit validation
  function automatic logic [6:0] bcd_dec(input logic [6:0] v);
    return ({4'b0, v[6:4]} * 7'd10) + {3'b0, v[3:0]};
  endfunction

  function automatic logic [6:0] val_mask(input int unsigned idx);
    return (idx == FLD_SEC || idx == FLD_MIN) ? 7'h7f : 7'h3f;
  endfunction

  function automatic logic field_ok(input int unsigned idx, input logic [7:0] v);
    logic [6:0] d;
    d = bcd_dec(v[6:0] & val_mask(idx));
    case (idx)
      FLD_SEC, FLD_MIN: return d <= 7'd59;
      FLD_HOUR:         return d <= 7'd23;
      default:          return d != 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ALARM_BASE = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [7:0]                  wdata_i,
  output logic [NUM_FIELDS-1:0][7:0]  alarm_o
);

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [ADDR_W-1:0] FLD_ADDR = ADDR_W'(ALARM_BASE + g);
    logic sel;
    assign sel = wr_en_i && (addr_i == FLD_ADDR);

    // R3 R4 R5: out-of-range BCD leaves the register untouched
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           alarm_o[g] <= 8'h00;
      else if (sel && field_ok(g, wdata_i))  alarm_o[g] <= wdata_i;
    end
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][7:0] alarm_i,
  input  logic [NUM_FIELDS-1:0][7:0] now_i,
  output rpt_e                       mode_o,
  output logic                       hit_o
);

  logic [NUM_FIELDS-1:0] msk, need, eq;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    localparam logic [6:0] VM = val_mask(g);
    assign msk[g] = alarm_i[g][7];
    assign eq[g]  = (alarm_i[g][6:0] & VM) == (now_i[g][6:0] & VM);
  end

  // R6..R10: mask pattern {date,hour,min,sec} picks the repeat rate
  always_comb begin
    unique case (msk)
      4'b0000: mode_o = RPT_MONTH;
      4'b1000: mode_o = RPT_DAY;
      4'b1100: mode_o = RPT_HOUR;
      4'b1110: mode_o = RPT_MIN;
      default: mode_o = RPT_SEC;
    endcase
  end

  always_comb begin
    unique case (mode_o)
      RPT_MONTH: need = 4'b1111;
      RPT_DAY:   need = 4'b0111;
      RPT_HOUR:  need = 4'b0011;
      RPT_MIN:   need = 4'b0001;
      default:   need = 4'b0000;
    endcase
  end

  assign hit_o = &(eq | ~need);

endmodule

// File: rtl/alarm_event.sv
module alarm_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic en_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);

  logic fire;
  assign fire = tick_i && hit_i;

  // R12: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (fire)   flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R11: one-cycle pulse per matching tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fire && en_i;
  end

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ALARM_BASE = 0,
  parameter int unsigned CTRL_ADDR  = 4,
  parameter int unsigned STAT_ADDR  = 5,
  parameter int unsigned EN_BIT     = 0,
  parameter int unsigned FLAG_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tick_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        date_i,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [NUM_FIELDS-1:0][7:0] alarm_q, now_w;
  logic alarm_en, alarm_flag, hit, clr;
  rpt_e mode;

  assign now_w[FLD_SEC]  = sec_i;
  assign now_w[FLD_MIN]  = min_i;
  assign now_w[FLD_HOUR] = hour_i;
  assign now_w[FLD_DATE] = date_i;

  alarm_regs #(.ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .alarm_o (alarm_q)
  );

  alarm_match i_match (
    .alarm_i (alarm_q),
    .now_i   (now_w),
    .mode_o  (mode),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           alarm_en <= 1'b0;
    else if (wr_en_i && addr_i == CTRL_A)  alarm_en <= wdata_i[EN_BIT];
  end

  assign clr = rd_en_i && (addr_i == STAT_A);

  alarm_event i_event (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .hit_i  (hit),
    .en_i   (alarm_en),
    .clr_i  (clr),
    .flag_o (alarm_flag),
    .irq_o  (irq_o)
  );

  // R2: read mux
  always_comb begin
    rdata_o = 8'h00;
    for (int unsigned i = 0; i < NUM_FIELDS; i++)
      if (addr_i == ADDR_W'(ALARM_BASE + i)) rdata_o = alarm_q[i];
    if (addr_i == CTRL_A) rdata_o[EN_BIT]   = alarm_en;
    if (addr_i == STAT_A) rdata_o[FLAG_BIT] = alarm_flag;
  end

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned ALARM_BASE = 0,
  parameter int unsigned STAT_ADDR  = 5
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic                       rd_en_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [7:0]                 wdata_i,
  input logic                       tick_i,
  input logic                       irq_o,
  input logic                       en_i,
  input logic                       flag_i,
  input logic [NUM_FIELDS-1:0][7:0] alarm_i
);

  localparam logic [ADDR_W-1:0] DATE_A = ADDR_W'(ALARM_BASE + FLD_DATE);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  a_r11_irq_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_i));

  a_r12_flag_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_i);

  a_r12_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !(rd_en_i && addr_i == STAT_A)) |=> flag_i);

  a_r3_sec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_dec(alarm_i[FLD_SEC][6:0]) <= 7'd59);

  a_r4_hour_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_dec({1'b0, alarm_i[FLD_HOUR][5:0]}) <= 7'd23);

  a_r5_date_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == DATE_A && bcd_dec({1'b0, wdata_i[5:0]}) == 7'd0)
      |=> $stable(alarm_i[FLD_DATE]));

endmodule

bind rtc_alarm_top rtc_alarm_chk #(
  .ADDR_W(ADDR_W), .ALARM_BASE(ALARM_BASE), .STAT_ADDR(STAT_ADDR)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (tick_i),
  .irq_o   (irq_o),
  .en_i    (alarm_en),
  .flag_i  (alarm_flag),
  .alarm_i (alarm_q)
);

// File: tb/test_rtc_alarm_top.sv
module test_rtc_alarm_top;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0, tick_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, sec_i = '0, min_i = '0, hour_i = '0, date_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int vectors = 0, misses = 0;

  // reference model state
  int m_al[4];
  bit m_en, m_flag, m_irq;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_alarm_top i_rtc_alarm_top (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .tick_i, .sec_i, .min_i, .hour_i, .date_i, .irq_o
  );

  function automatic int dec(int v);
    return ((v >> 4) & 15) * 10 + (v & 15);
  endfunction

  function automatic bit legal(int idx, int v);
    if (idx <= 1) return dec(v & 127) < 60;
    if (idx == 2) return dec(v & 63) < 24;
    return dec(v & 63) > 0;
  endfunction

  // number of low-order fields (sec first) that must agree
  function automatic bit ref_hit(int t0, int t1, int t2, int t3);
    int t[4];
    int n;
    bit ok;
    t[0] = t0; t[1] = t1; t[2] = t2; t[3] = t3;
    if      (m_al[3] < 128 && m_al[2] < 128 && m_al[1] < 128 && m_al[0] < 128) n = 4;
    else if (m_al[3] >= 128 && m_al[2] < 128 && m_al[1] < 128 && m_al[0] < 128) n = 3;
    else if (m_al[3] >= 128 && m_al[2] >= 128 && m_al[1] < 128 && m_al[0] < 128) n = 2;
    else if (m_al[3] >= 128 && m_al[2] >= 128 && m_al[1] >= 128 && m_al[0] < 128) n = 1;
    else n = 0;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      int vm;
      vm = (i < 2) ? 127 : 63;
      if ((m_al[i] & vm) != (t[i] & vm)) ok = 0;
    end
    return ok;
  endfunction

  function automatic logic [7:0] ref_rd(int a);
    if (a < 4)  return m_al[a][7:0];
    if (a == 4) return {7'b0, m_en};
    if (a == 5) return {7'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, bit re, int a, int d, bit tk,
                     int s, int mi, int h, int dt, string tag);
    bit hit, nflag, nirq;
    wr_en_i = we; rd_en_i = re; addr_i = 3'(a); wdata_i = 8'(d);
    tick_i = tk; sec_i = 8'(s); min_i = 8'(mi); hour_i = 8'(h); date_i = 8'(dt);
    hit = tk && ref_hit(s, mi, h, dt);
    nflag = m_flag;
    if (re && a == 5) nflag = 0;
    if (hit) nflag = 1;
    nirq = hit && m_en;
    @(posedge clk_i);
    #1;
    m_flag = nflag;
    m_irq = nirq;
    if (we) begin
      if (a < 4 && legal(a, d)) m_al[a] = d;
      if (a == 4) m_en = d[0];
    end
    chk(tag, {7'b0, irq_o}, {7'b0, m_irq}, "irq_o");
    chk(tag, rdata_o, ref_rd(a), "rdata_o");
  endtask

  task automatic wr(int a, int d, string tag);
    cyc(1, 0, a, d, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(0, 0, a, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic tk(int s, int mi, int h, int dt, string tag);
    cyc(0, 0, 5, 0, 1, s, mi, h, dt, tag);
    cyc(0, 0, 5, 0, 0, s, mi, h, dt, tag);   // pulse must be gone
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wr_en_i = 0; rd_en_i = 0; tick_i = 0;
    repeat (3) @(posedge clk_i);
    foreach (m_al[i]) m_al[i] = 0;
    m_en = 0; m_flag = 0; m_irq = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic set_alarm(int s, int mi, int h, int dt, string tag);
    wr(0, s, tag); wr(1, mi, tag); wr(2, h, tag); wr(3, dt, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(a, "R1");

    // R2 map and readback
    set_alarm(8'h30, 8'h15, 8'h12, 8'h07, "R2");
    for (int a = 0; a < 8; a++) rd(a, "R2");

    // R3 seconds/minutes range
    wr(0, 8'h60, "R3"); wr(0, 8'h5a, "R3"); wr(1, 8'h7f, "R3");
    wr(0, 8'h59, "R3"); wr(0, 8'h30, "R3");
    // R4 hours range
    wr(2, 8'h24, "R4"); wr(2, 8'h1e, "R4"); wr(2, 8'h23, "R4"); wr(2, 8'h12, "R4");
    // R5 date nonzero
    wr(3, 8'h00, "R5"); wr(3, 8'h40, "R5"); wr(3, 8'h31, "R5"); wr(3, 8'h07, "R5");

    wr(4, 8'h01, "R2");
    // R6 monthly
    tk(8'h30, 8'h15, 8'h12, 8'h07, "R6");
    tk(8'h30, 8'h15, 8'h12, 8'h08, "R6");
    tk(8'h31, 8'h15, 8'h12, 8'h07, "R6");
    // R11 no tick, no pulse
    cyc(0, 0, 5, 0, 0, 8'h30, 8'h15, 8'h12, 8'h07, "R11");
    // R12 read clears flag
    cyc(0, 1, 5, 0, 0, 0, 0, 0, 0, "R12");
    rd(5, "R12");

    // R7 daily
    wr(3, 8'h87, "R7");
    tk(8'h30, 8'h15, 8'h12, 8'h09, "R7");
    tk(8'h30, 8'h15, 8'h13, 8'h09, "R7");
    // R8 hourly
    wr(2, 8'h92, "R8");
    tk(8'h30, 8'h15, 8'h05, 8'h01, "R8");
    tk(8'h30, 8'h16, 8'h05, 8'h01, "R8");
    // R9 every minute
    wr(1, 8'h95, "R9");
    tk(8'h30, 8'h44, 8'h05, 8'h01, "R9");
    tk(8'h31, 8'h44, 8'h05, 8'h01, "R9");
    // R10 all masked, then odd patterns
    wr(0, 8'hb0, "R10");
    tk(8'h01, 8'h02, 8'h03, 8'h04, "R10");
    set_alarm(8'hb0, 8'h15, 8'h12, 8'h07, "R10");
    tk(8'h01, 8'h02, 8'h03, 8'h04, "R10");
    set_alarm(8'h30, 8'h15, 8'h92, 8'h07, "R10");
    tk(8'h01, 8'h02, 8'h03, 8'h04, "R10");

    // R11 R12 enable off: flag still set, no pulse
    cyc(0, 1, 5, 0, 0, 0, 0, 0, 0, "R12");
    wr(4, 8'h00, "R11");
    tk(8'h01, 8'h02, 8'h03, 8'h04, "R11");
    rd(5, "R12");
    // R12 set wins over clear in same cycle
    cyc(0, 1, 5, 0, 1, 8'h01, 8'h02, 8'h03, 8'h04, "R12");
    rd(5, "R12");

    // mixed traffic
    wr(4, 8'h01, "R11");
    for (int i = 0; i < 600; i++) begin
      int s, mi, h, dt;
      s  = ($urandom % 2) ? m_al[0] : $urandom % 128;
      mi = ($urandom % 2) ? m_al[1] : $urandom % 128;
      h  = ($urandom % 2) ? m_al[2] : $urandom % 64;
      dt = ($urandom % 2) ? m_al[3] : $urandom % 64;
      cyc($urandom % 4 == 0, $urandom % 5 == 0, $urandom % 8,
          ($urandom % 2) ? ($urandom % 256) : (($urandom % 2) ? 8'h80 : 8'h00) | ($urandom % 8'h24),
          $urandom % 3 == 0, s, mi, h, dt, "R11");
    end

    // R1 reset clears flag and irq
    cyc(0, 0, 5, 0, 1, 8'h00, 8'h00, 8'h00, 8'h01, "R1");
    do_reset();
    rd(5, "R1");
    rd(4, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule